// File: doc/BRIEF.md
# Windowed Watchdog Supervisor

This block watches a host microcontroller and asks for a system reset when the host stops servicing it correctly. The host services the watchdog by writing its control register. The register interface delivers that write to the block as a one-cycle strobe, together with the 3-bit period code carried by the write. The block counts ticks of a slow time base that is supplied from outside, nominally 1 kHz. The period is `BASE_TICKS << code` ticks. With the default `BASE_TICKS = 8` this runs from 8 to 1024 ticks, and the power-on code selects 128.

The supervising behaviour follows from the system operating mode and one mode-control bit. In window mode the host may only service the watchdog in the second half of each period. In timeout mode it may service it at any time before expiry. In off mode the count is held and no reset request is ever made. When the host gets it wrong, the block emits a single-cycle reset request and records the cause in a sticky flag. The flag stays set until the host acknowledges a status read.

Top module: `wdg_supervisor`

## Requirements
- R1: The mode is derived combinationally from `sys_mode_i` (01 = standby, 11 = normal, 00/10 = any other state) and `mode_ctl_i`:
  - normal with control 0 gives window mode (`wd_mode_o` = 01);
  - normal with control 1, or standby with control 0, gives timeout mode (`wd_mode_o` = 10);
  - every other combination gives off mode (`wd_mode_o` = 00).
- R2: After reset, `per_sel_o` is 100b, the flag and the reset request are low, and the mode is off. The period for code c is `BASE_TICKS << c` ticks.
- R3: In window mode, a trigger whose code equals the current code, arriving while fewer than half the period's ticks have elapsed, raises a reset request with `cause_early_o` = 1 and restarts the period.
- R4: In window mode, a trigger with the current code, arriving once at least half the period's ticks have elapsed, is accepted without a reset request and restarts the period.
- R5: In window or timeout mode, if no trigger arrives, the tick that completes the period raises a reset request with `cause_early_o` = 0 and restarts the period. A trigger in the same cycle as that tick takes priority.
- R6: In timeout mode, any trigger before expiry is accepted and restarts the period.
- R7: In off mode the count is held at zero and no reset request is made, whatever the ticks and triggers.
- R8: A trigger that carries a code different from `per_sel_o` loads that code and restarts the period with it. It never causes a reset request, even in the first half of a window.
- R9: `rst_req_o` is a one-clock pulse, registered one cycle after the input cycle that caused it.
- R10: `wd_flag_o` is set together with each reset request and holds until a cycle with `stat_rd_i` high clears it. A new request in the same cycle wins over the clear. `cause_early_o` holds the cause of the latest request.
- R11: Any change of the derived mode restarts the count from zero in that cycle, and no reset request is made in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe of the slow time base |
| sys_mode_i | input | 2 | System operating mode (01 standby, 11 normal) |
| mode_ctl_i | input | 1 | Mode-control bit |
| trig_i | input | 1 | Watchdog register write strobe (trigger) |
| trig_per_i | input | 3 | Period code carried by the write |
| stat_rd_i | input | 1 | Status read acknowledge, clears the sticky flag |
| rst_req_o | output | 1 | One-cycle system reset request |
| wd_flag_o | output | 1 | Sticky: a watchdog reset request occurred |
| cause_early_o | output | 1 | Cause of the latest request: 1 early trigger, 0 expiry |
| wd_mode_o | output | 2 | Current mode: 00 off, 01 window, 10 timeout |
| per_sel_o | output | 3 | Current period code |

## Verification
The checker watches a set of rules on every cycle:
- the tick count stays below the period length;
- off mode never leads to a request;
- an early cause can only follow a trigger in window mode, and timeout mode never reports an early cause;
- the sticky flag accompanies every request and survives until it is read.

Only the bench scenarios can show that requests land on the exact tick or trigger the requirements predict. The same holds for the half-period boundary, period reloads, restarts on a mode change and the power-on code. For these the bench runs a cycle-level reference model alongside directed and random stimulus.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   typedef enum logic [1:0] {
      WDG_OFF     = 2'b00,
      WDG_WINDOW  = 2'b01,
      WDG_TIMEOUT = 2'b10
   } wdg_mode_e;

   localparam logic [1:0] SYS_STANDBY = 2'b01;
   localparam logic [1:0] SYS_NORMAL  = 2'b11;

endpackage

// File: rtl/wdg_mode_sel.sv
module wdg_mode_sel
   import wdg_pkg::*;
(
   input  logic [1:0] sys_mode_i,
   input  logic       mode_ctl_i,
   output wdg_mode_e  mode_o
);

   always_comb begin
      mode_o = WDG_OFF;
      if (sys_mode_i == SYS_NORMAL)
         mode_o = mode_ctl_i ? WDG_TIMEOUT : WDG_WINDOW;
      else if (sys_mode_i == SYS_STANDBY && !mode_ctl_i)
         mode_o = WDG_TIMEOUT;
   end

endmodule

// File: rtl/wdg_period_lut.sv
module wdg_period_lut #(
   parameter int BASE_TICKS = 8,
   parameter int CODE_W     = 3,
   parameter int LIM_W      = 11
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [LIM_W-1:0]  limit_o,
   output logic [LIM_W-1:0]  half_o
);

   localparam int N_CODES = 1 << CODE_W;

   logic [LIM_W-1:0] tbl [N_CODES];

   // Doubling table, one entry per code.
   for (genvar i = 0; i < N_CODES; i++) begin : g_tbl
      assign tbl[i] = LIM_W'(BASE_TICKS) << i;
   end

   assign limit_o = tbl[code_i];
   assign half_o  = limit_o >> 1;

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
   import wdg_pkg::*;
#(
   parameter int LIM_W = 11
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  wdg_mode_e        mode_i,
   input  logic             mode_chg_i,
   input  logic             tick_i,
   input  logic             trig_i,
   input  logic             code_chg_i,
   input  logic [LIM_W-1:0] limit_i,
   input  logic [LIM_W-1:0] half_i,
   output logic             fire_o,
   output logic             early_o,
   output logic [LIM_W-1:0] cnt_o
);

   logic [LIM_W-1:0] cnt_q, cnt_d;

   always_comb begin
      cnt_d   = cnt_q;
      fire_o  = 1'b0;
      early_o = 1'b0;
      if (mode_chg_i || mode_i == WDG_OFF) begin
         cnt_d = '0;
      end else if (trig_i) begin
         cnt_d = '0;
         if (!code_chg_i && mode_i == WDG_WINDOW && cnt_q < half_i) begin
            fire_o  = 1'b1;
            early_o = 1'b1;
         end
      end else if (tick_i) begin
         if (cnt_q == limit_i - 1'b1) begin
            fire_o = 1'b1;
            cnt_d  = '0;
         end else begin
            cnt_d = cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
   import wdg_pkg::*;
#(
   parameter int          BASE_TICKS = 8,
   parameter int          CODE_W     = 3,
   parameter logic [CODE_W-1:0] RST_CODE = 3'b100,
   localparam int         LIM_W      = $clog2((BASE_TICKS << ((1 << CODE_W) - 1)) + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic [1:0]        sys_mode_i,
   input  logic              mode_ctl_i,
   input  logic              trig_i,
   input  logic [CODE_W-1:0] trig_per_i,
   input  logic              stat_rd_i,
   output logic              rst_req_o,
   output logic              wd_flag_o,
   output logic              cause_early_o,
   output logic [1:0]        wd_mode_o,
   output logic [CODE_W-1:0] per_sel_o
);

   if (BASE_TICKS < 2 || (BASE_TICKS % 2) != 0) begin : g_chk_base
      $error("wdg_supervisor: BASE_TICKS must be even and at least 2");
   end
   if (CODE_W < 1 || CODE_W > 4) begin : g_chk_code
      $error("wdg_supervisor: CODE_W must be 1..4");
   end

   wdg_mode_e         mode_now, mode_q;
   logic [CODE_W-1:0] per_q;
   logic [LIM_W-1:0]  limit, half, cnt;
   logic              fire, early, code_chg;
   logic              req_q, flag_q, early_q;

   wdg_mode_sel u_mode (
      .sys_mode_i (sys_mode_i),
      .mode_ctl_i (mode_ctl_i),
      .mode_o     (mode_now)
   );

   wdg_period_lut #(
      .BASE_TICKS (BASE_TICKS),
      .CODE_W     (CODE_W),
      .LIM_W      (LIM_W)
   ) u_lut (
      .code_i  (per_q),
      .limit_o (limit),
      .half_o  (half)
   );

   assign code_chg = trig_i && (trig_per_i != per_q);

   wdg_counter #(.LIM_W(LIM_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_i     (mode_now),
      .mode_chg_i (mode_now != mode_q),
      .tick_i     (tick_i),
      .trig_i     (trig_i),
      .code_chg_i (code_chg),
      .limit_i    (limit),
      .half_i     (half),
      .fire_o     (fire),
      .early_o    (early),
      .cnt_o      (cnt)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q  <= WDG_OFF;
         per_q   <= RST_CODE;
         req_q   <= 1'b0;
         flag_q  <= 1'b0;
         early_q <= 1'b0;
      end else begin
         mode_q <= mode_now;
         req_q  <= fire;
         if (trig_i) per_q <= trig_per_i;
         if (fire) begin
            flag_q  <= 1'b1;
            early_q <= early;
         end else if (stat_rd_i) begin
            flag_q <= 1'b0;
         end
      end
   end

   assign rst_req_o     = req_q;
   assign wd_flag_o     = flag_q;
   assign cause_early_o = early_q;
   assign wd_mode_o     = mode_now;
   assign per_sel_o     = per_q;

endmodule

// File: rtl/wdg_supervisor_chk.sv
module wdg_supervisor_chk #(
   parameter int LIM_W = 11
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             trig_i,
   input logic             stat_rd_i,
   input logic             rst_req_o,
   input logic             wd_flag_o,
   input logic             cause_early_o,
   input logic [1:0]       wd_mode_o,
   input logic [LIM_W-1:0] cnt,
   input logic [LIM_W-1:0] limit
);

   // R5: the tick count never reaches the period length
   p_cnt_in_period_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt < limit);

   // R7: off mode never produces a request
   p_off_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wd_mode_o == 2'b00 |=> !rst_req_o);

   // R3: an early cause only follows a trigger seen in window mode
   p_early_from_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wd_mode_o != 2'b01 || !trig_i |=> !(rst_req_o && cause_early_o));

   // R6: a timeout-mode cycle never yields an early cause
   p_timeout_no_early_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wd_mode_o == 2'b10 |=> !(rst_req_o && cause_early_o));

   // R10: the flag accompanies every request
   p_flag_with_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_req_o |-> wd_flag_o);

   // R10: the flag holds until a read
   p_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wd_flag_o && !stat_rd_i |=> wd_flag_o);

   // R10: a read clears the flag unless a new request arrives
   p_flag_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stat_rd_i |=> rst_req_o || !wd_flag_o);

endmodule

bind wdg_supervisor wdg_supervisor_chk #(.LIM_W(LIM_W)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .trig_i        (trig_i),
   .stat_rd_i     (stat_rd_i),
   .rst_req_o     (rst_req_o),
   .wd_flag_o     (wd_flag_o),
   .cause_early_o (cause_early_o),
   .wd_mode_o     (wd_mode_o),
   .cnt           (cnt),
   .limit         (limit)
);

// File: tb/sim_wdg_supervisor.sv
`timescale 1ns/1ps
module sim_wdg_supervisor;

   localparam int BASE = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, trig = 1'b0, ctl = 1'b0, rd = 1'b0;
   logic [1:0] sys = 2'b00;
   logic [2:0] per = 3'd0;
   logic       req, flag, early;
   logic [1:0] mode;
   logic [2:0] per_sel;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // reference model state
   int       m_cnt = 0;
   logic [1:0] m_mode = 2'b00;
   logic [2:0] m_per = 3'b100;
   bit       m_flag = 0, m_early = 0;

   always #2.5 clk = ~clk;

   wdg_supervisor u0 (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sys_mode_i(sys),
      .mode_ctl_i(ctl), .trig_i(trig), .trig_per_i(per), .stat_rd_i(rd),
      .rst_req_o(req), .wd_flag_o(flag), .cause_early_o(early),
      .wd_mode_o(mode), .per_sel_o(per_sel)
   );

   function automatic logic [1:0] mode_of(logic [1:0] s, logic c);
      if (s == 2'b11) return c ? 2'b10 : 2'b01;
      if (s == 2'b01 && !c) return 2'b10;
      return 2'b00;
   endfunction

   function automatic int limit_of(logic [2:0] c);
      return BASE << c;
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // One cycle: drive, model, clock, check.
   task automatic step(bit t, bit g, logic [2:0] p, bit r, logic [1:0] s, bit c);
      logic [1:0] md;
      bit fire, e;
      md = mode_of(s, c);
      fire = 0; e = 0;
      if (md != m_mode) begin
         m_cnt = 0; m_mode = md;                        // R11
      end else if (md == 2'b00) begin
         m_cnt = 0;                                     // R7
      end else if (g) begin
         if (p == m_per) begin
            if (md == 2'b01 && m_cnt < limit_of(m_per) / 2) begin
               fire = 1; e = 1;                         // R3
            end
         end
         m_cnt = 0;                                     // R4 R6 R8
      end else if (t) begin
         if (m_cnt == limit_of(m_per) - 1) begin
            fire = 1; m_cnt = 0;                        // R5
         end else m_cnt++;
      end
      if (g) m_per = p;
      if (fire) begin m_flag = 1; m_early = e; end
      else if (r) m_flag = 0;
      tick = t; trig = g; per = p; rd = r; sys = s; ctl = c;
      #0.1;
      check(mode == md, "R1 mode", mode, md);
      @(posedge clk);
      @(negedge clk);
      check(req == fire, fire ? (e ? "R3 early request" : "R5 expiry request")
                              : "R9 request pulse", req, fire);
      check(flag == m_flag, "R10 flag", flag, m_flag);
      if (m_flag) check(early == m_early, "R10 cause", early, m_early);
      check(per_sel == m_per, "R8 period code", per_sel, m_per);
      tick = 0; trig = 0; rd = 0;
   endtask

   task automatic ticks(int n, logic [1:0] s, bit c);
      for (int i = 0; i < n; i++) step(1, 0, m_per, 0, s, c);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      check(per_sel == 3'b100, "R2 reset code", per_sel, 4);
      check(req == 0, "R2 reset request", req, 0);
      check(flag == 0, "R2 reset flag", flag, 0);
      check(mode == 2'b00, "R2 reset mode", mode, 0);

      // R1 full mode table
      for (int k = 0; k < 8; k++) step(0, 0, m_per, 0, k[2:1], k[0]);

      // R2: default period 128 ticks in timeout mode
      step(0, 0, m_per, 0, 2'b01, 0);
      ticks(127, 2'b01, 0);
      check(flag == 0, "R2 no early expiry", flag, 0);
      ticks(1, 2'b01, 0);
      check(flag == 1, "R2 expiry at 128", flag, 1);
      step(0, 0, m_per, 1, 2'b01, 0);

      // Window mode, code 0 (8 ticks)
      step(0, 0, m_per, 0, 2'b11, 0);
      step(0, 1, 3'd0, 0, 2'b11, 0);          // R8 code change, no request
      ticks(3, 2'b11, 0);
      step(0, 1, 3'd0, 0, 2'b11, 0);          // R3 early trigger
      step(0, 0, m_per, 1, 2'b11, 0);          // R10 clear
      ticks(4, 2'b11, 0);
      step(0, 1, 3'd0, 0, 2'b11, 0);          // R4 exactly at half
      ticks(4, 2'b11, 0);
      step(1, 1, 3'd0, 0, 2'b11, 0);          // R5 trigger beats tick
      ticks(8, 2'b11, 0);                       // R5 expiry
      ticks(2, 2'b11, 0);
      step(0, 1, 3'd2, 1, 2'b11, 0);          // R8 change in first half; R10 clear

      // R6 timeout: early trigger accepted
      ticks(1, 2'b11, 1);
      step(0, 1, 3'd2, 0, 2'b11, 1);
      ticks(31, 2'b11, 1);
      step(0, 1, 3'd2, 0, 2'b11, 1);

      // R7 off mode
      ticks(600, 2'b01, 1);
      step(0, 1, 3'd2, 0, 2'b01, 1);

      // R11 mode change restarts count
      ticks(20, 2'b11, 1);
      ticks(20, 2'b01, 0);

      // constrained random
      for (int i = 0; i < 30000; i++) begin
         bit t, g, r;
         logic [2:0] p;
         logic [1:0] s;
         bit c;
         t = ($urandom % 2) == 0;
         g = ($urandom % 24) == 0;
         r = ($urandom % 40) == 0;
         p = (($urandom % 8) == 0) ? 3'($urandom % 3) : m_per;
         s = (($urandom % 500) == 0) ? 2'($urandom) : sys;
         c = (($urandom % 500) == 0) ? 1'($urandom) : ctl;
         step(t, g, p, r, s, c);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule